// File: doc/BRIEF.md
# Receive Descriptor List Walker

This block walks a list of receive descriptors in memory for an Ethernet receive path. It reads each descriptor through a simple word-wide memory port. A descriptor is either four words or eight words, chosen by a mode input. The block checks whether the hardware side owns the descriptor. It then hands the descriptor's buffers, each an address and a byte count, one at a time to an external data mover. When the mover reports the end of the frame, or when every usable buffer of the descriptor has been filled, the block writes back a status word with ownership returned to the host. It then moves on to the next descriptor.

The next descriptor is found in one of two ways. In ring stepping, the walker advances by one descriptor size, or returns to the list base when the descriptor is flagged as the last of the ring. In chaining, it follows a pointer held in the descriptor's fourth word. When the walker meets a descriptor the host still owns, it raises an unavailable flag and goes idle. It reads that same descriptor again only when the host pulses a poll request. The first poll after reset starts the walk at the list base. Moving the frame data itself is left to the mover.

Top module: `rx_desc_walker`

## Requirements
- R1: When word 0 of a descriptor has bit 31 at 0, the walker issues no transfer and no further memory access, and raises `descUnavail`. It stays there until `pollDemand` is pulsed. It then re-reads word 0 at the same descriptor address.
- R2: The status write-back to word 0 always has bit 31 = 0. Bit 30 is the destination-filter failure reported with the frame-ending transfer. Bit 8 is 1 when the frame ended in this descriptor. Bit 0 equals the eight-word mode bit. All other bits are 0.
- R3: With `extMode` = 0, the walker reads exactly words 0 to 3, at descriptor address +0, +4, +8 and +12. It writes only word 0. A ring step advances the address by 16.
- R4: With `extMode` = 1, the walker reads words 0 to 7. It writes word 4 (address +16) with the `extStatus` value sampled at the last completed transfer of the descriptor, or 0 if no transfer was made. It then writes word 0. A ring step advances the address by 32.
- R5: Word 1 bits [12:0] give the buffer 1 byte count and bits [28:16] the buffer 2 byte count. Buffer 1 (address in word 2) is offered before buffer 2 (address in word 3).
- R6: When a transfer completes with `xferFrameEnd` = 1, the descriptor is closed at once, and buffer 2 is not offered.
- R7: When word 1 bit 14 (chain) is 1, buffer 2 is never offered and the next descriptor address is word 3. This takes priority over bit 15.
- R8: When word 1 bit 15 (end of ring) is 1 and bit 14 is 0, the next descriptor address is `listBase`.
- R9: A buffer with a byte count of 0 is never offered. When both counts are 0, the descriptor is closed with no transfer, and the status word has bits 31, 30 and 8 clear.
- R10: `memReq` stays asserted with a stable address and direction until `memAck`. Every address is a multiple of 4. A memory access and a transfer offer are never active together.
- R11: `xferValid` stays asserted with a stable `xferAddr` and `xferLen` until `xferDone`.
- R12: After reset, `memReq`, `xferValid` and `descUnavail` are 0, and no memory access is made until the first `pollDemand`. That poll starts the walk at `listBase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extMode | input | 1 | 1 selects eight-word descriptors, 0 selects four-word descriptors |
| listBase | input | ADDR_W | Byte address of the first descriptor of the list |
| pollDemand | input | 1 | Host pulse: start the walk, or retry after a stall |
| descUnavail | output | 1 | The current descriptor is owned by the host; the walker is stalled |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | ADDR_W | Byte address of the accessed word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access accepted; read data valid in the same cycle |
| memRdata | input | 32 | Read data |
| xferValid | output | 1 | Buffer offered to the data mover |
| xferAddr | output | 32 | Buffer start address |
| xferLen | output | 13 | Buffer byte count |
| xferDone | input | 1 | Mover finished with the offered buffer |
| xferFrameEnd | input | 1 | With xferDone: the frame ended in this buffer |
| xferDaFail | input | 1 | With xferDone: the frame failed destination filtering |
| extStatus | input | 32 | Extended status value to record in eight-word mode |

## Verification
The bench builds the walker with `ADDR_W` = 12, so the whole descriptor space fits in a small model memory with a 4 KiB address range. This makes every follow-on address observable through the stalled fetch that it produces: base + 16, base + 32, the base itself on an end-of-ring wrap, and a chained pointer. The model memory grants requests only on alternate cycles, so the hold rule is exercised. The mover model ends the frame on a chosen byte count, so frame ending in buffer 1, frame ending in buffer 2, and buffers filling without a frame end can each be reached in both descriptor sizes.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

  localparam int WORD_W    = 32;
  localparam int SIZE_W    = 13;
  localparam int OWN_BIT   = 31;
  localparam int DAF_BIT   = 30;
  localparam int LAST_BIT  = 8;
  localparam int CHAIN_BIT = 14;
  localparam int EOR_BIT   = 15;
  localparam int SIZE2_LSB = 16;
  localparam int BASIC_LAST_IDX = 3;
  localparam int EXT_LAST_IDX   = 7;
  localparam int EXT_WB_IDX     = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD0,
    ST_RDREST,
    ST_STALL,
    ST_BUF1,
    ST_BUF2,
    ST_WBX,
    ST_WB0,
    ST_NEXT
  } rdw_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       memRd;
    logic       memWr;
    logic [2:0] wordIdx;
    logic       capture;
    logic       wbExt;
    logic       loadBase;
    logic       advance;
    logic       xferOn;
    logic       xferBuf2;
    logic       latchDone;
    logic       clearStat;
  } rdw_ctl_t;

  // descriptor facts from datapath to control
  typedef struct packed {
    logic own;
    logic size1Zero;
    logic size2Zero;
    logic chain;
  } rdw_flags_t;

endpackage

// File: rtl/rdw_ctrl.sv
module rdw_ctrl
  import rdw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extMode,
  input  logic       pollDemand,
  input  logic       memAck,
  input  logic       xferDone,
  input  logic       xferFrameEnd,
  input  rdw_flags_t flags,
  output rdw_ctl_t   ctl,
  output logic       descUnavail
);

  rdw_state_e state, stateNext;
  logic [2:0] idx;
  logic [2:0] lastIdx;
  rdw_state_e wbState;
  rdw_state_e afterBuf1;

  assign lastIdx   = extMode ? 3'(EXT_LAST_IDX) : 3'(BASIC_LAST_IDX);
  assign wbState   = extMode ? ST_WBX : ST_WB0;
  assign afterBuf1 = (flags.chain || flags.size2Zero) ? wbState : ST_BUF2;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (pollDemand) begin
          ctl.loadBase = 1'b1;
          stateNext    = ST_RD0;
        end
      end
      ST_RD0: begin
        ctl.memRd   = 1'b1;
        ctl.wordIdx = 3'd0;
        if (memAck) begin
          ctl.capture   = 1'b1;
          ctl.clearStat = 1'b1;
          stateNext     = ST_RDREST;
        end
      end
      ST_RDREST: begin
        if (!flags.own) begin
          stateNext = ST_STALL;
        end else begin
          ctl.memRd   = 1'b1;
          ctl.wordIdx = idx;
          if (memAck) begin
            ctl.capture = 1'b1;
            if (idx == lastIdx) stateNext = ST_BUF1;
          end
        end
      end
      ST_STALL: begin
        if (pollDemand) stateNext = ST_RD0;
      end
      ST_BUF1: begin
        if (flags.size1Zero) begin
          stateNext = afterBuf1;
        end else begin
          ctl.xferOn = 1'b1;
          if (xferDone) begin
            ctl.latchDone = 1'b1;
            stateNext     = xferFrameEnd ? wbState : afterBuf1;
          end
        end
      end
      ST_BUF2: begin
        if (flags.size2Zero) begin
          stateNext = wbState;
        end else begin
          ctl.xferOn   = 1'b1;
          ctl.xferBuf2 = 1'b1;
          if (xferDone) begin
            ctl.latchDone = 1'b1;
            stateNext     = wbState;
          end
        end
      end
      ST_WBX: begin
        ctl.memWr   = 1'b1;
        ctl.wbExt   = 1'b1;
        ctl.wordIdx = 3'(EXT_WB_IDX);
        if (memAck) stateNext = ST_WB0;
      end
      ST_WB0: begin
        ctl.memWr   = 1'b1;
        ctl.wordIdx = 3'd0;
        if (memAck) stateNext = ST_NEXT;
      end
      ST_NEXT: begin
        ctl.advance = 1'b1;
        stateNext   = ST_RD0;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= 3'd1;
    end else begin
      state <= stateNext;
      if (state == ST_RD0 && memAck) begin
        idx <= 3'd1;
      end else if (state == ST_RDREST && flags.own && memAck) begin
        idx <= idx + 3'd1;
      end
    end
  end

  assign descUnavail = (state == ST_STALL);

endmodule

// File: rtl/rdw_datapath.sv
module rdw_datapath
  import rdw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  rdw_ctl_t            ctl,
  input  logic                extMode,
  input  logic [ADDR_W-1:0]   listBase,
  input  logic [WORD_W-1:0]   memRdata,
  input  logic                xferFrameEnd,
  input  logic                xferDaFail,
  input  logic [WORD_W-1:0]   extStatus,
  output rdw_flags_t          flags,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWdata,
  output logic                xferValid,
  output logic [WORD_W-1:0]   xferAddr,
  output logic [SIZE_W-1:0]   xferLen
);

  localparam int STEP_BASIC = (BASIC_LAST_IDX + 1) * 4;
  localparam int STEP_EXT   = (EXT_LAST_IDX + 1) * 4;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic              ownQ;
  logic [WORD_W-1:0] descWord [1:3];
  logic              statLast;
  logic              statDaf;
  logic [WORD_W-1:0] extLatch;
  logic [WORD_W-1:0] statusWord;
  logic [SIZE_W-1:0] size1;
  logic [SIZE_W-1:0] size2;
  logic              chainBit;
  logic              eorBit;
  logic              unusedW1;

  // capture registers for the control and pointer words
  for (genvar g = 1; g <= 3; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        descWord[g] <= '0;
      end else if (ctl.capture && ctl.wordIdx == 3'(g)) begin
        descWord[g] <= memRdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownQ <= 1'b0;
    end else if (ctl.capture && ctl.wordIdx == 3'd0) begin
      ownQ <= memRdata[OWN_BIT];
    end
  end

  assign size1    = descWord[1][SIZE_W-1:0];
  assign size2    = descWord[1][SIZE2_LSB +: SIZE_W];
  assign chainBit = descWord[1][CHAIN_BIT];
  assign eorBit   = descWord[1][EOR_BIT];
  assign unusedW1 = ^{descWord[1][WORD_W-1:SIZE2_LSB+SIZE_W], descWord[1][SIZE_W]};

  assign flags.own       = ownQ;
  assign flags.size1Zero = (size1 == '0);
  assign flags.size2Zero = (size2 == '0);
  assign flags.chain     = chainBit;

  // per-descriptor completion record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statLast <= 1'b0;
      statDaf  <= 1'b0;
      extLatch <= '0;
    end else if (ctl.clearStat) begin
      statLast <= 1'b0;
      statDaf  <= 1'b0;
      extLatch <= '0;
    end else if (ctl.latchDone) begin
      extLatch <= extStatus;
      if (xferFrameEnd) begin
        statLast <= 1'b1;
        statDaf  <= xferDaFail;
      end
    end
  end

  // follow-on descriptor address
  always_comb begin
    if (chainBit)    nextAddr = descWord[3][ADDR_W-1:0];
    else if (eorBit) nextAddr = listBase;
    else             nextAddr = curAddr + ADDR_W'(extMode ? STEP_EXT : STEP_BASIC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (ctl.loadBase) begin
      curAddr <= listBase;
    end else if (ctl.advance) begin
      curAddr <= nextAddr;
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[DAF_BIT]   = statDaf;
    statusWord[LAST_BIT]  = statLast;
    statusWord[0]         = extMode;
  end

  assign memReq    = ctl.memRd | ctl.memWr;
  assign memWe     = ctl.memWr;
  assign memAddr   = curAddr + ADDR_W'({ctl.wordIdx, 2'b00});
  assign memWdata  = ctl.wbExt ? extLatch : statusWord;
  assign xferValid = ctl.xferOn;
  assign xferAddr  = ctl.xferBuf2 ? descWord[3] : descWord[2];
  assign xferLen   = ctl.xferBuf2 ? size2 : size1;

endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
  import rdw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extMode,
  input  logic [ADDR_W-1:0] listBase,
  input  logic              pollDemand,
  output logic              descUnavail,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              xferValid,
  output logic [31:0]       xferAddr,
  output logic [12:0]       xferLen,
  input  logic              xferDone,
  input  logic              xferFrameEnd,
  input  logic              xferDaFail,
  input  logic [31:0]       extStatus
);

  rdw_ctl_t   ctl;
  rdw_flags_t flags;

  rdw_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .extMode      (extMode),
    .pollDemand   (pollDemand),
    .memAck       (memAck),
    .xferDone     (xferDone),
    .xferFrameEnd (xferFrameEnd),
    .flags        (flags),
    .ctl          (ctl),
    .descUnavail  (descUnavail)
  );

  rdw_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .extMode      (extMode),
    .listBase     (listBase),
    .memRdata     (memRdata),
    .xferFrameEnd (xferFrameEnd),
    .xferDaFail   (xferDaFail),
    .extStatus    (extStatus),
    .flags        (flags),
    .memReq       (memReq),
    .memWe        (memWe),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .xferValid    (xferValid),
    .xferAddr     (xferAddr),
    .xferLen      (xferLen)
  );

endmodule

// File: rtl/rdw_walker_chk.sv
module rdw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              extMode,
  input logic              pollDemand,
  input logic              descUnavail,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memAck,
  input logic              xferValid,
  input logic [31:0]       xferAddr,
  input logic [12:0]       xferLen,
  input logic              xferDone
);

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    descUnavail |-> !memReq && !xferValid) else $error("stall not quiet"); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    descUnavail && !pollDemand |=> descUnavail) else $error("stall left without poll"); // R1

  AST_BASIC_WB_OWN: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && !extMode |-> !memWdata[31]) else $error("write-back keeps ownership"); // R2

  AST_ZERO_LEN_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> xferLen != 13'd0) else $error("zero-length buffer offered"); // R9

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)) else $error("memory request dropped"); // R10

  AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00) else $error("unaligned access"); // R10

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && xferValid)) else $error("memory and transfer together"); // R10

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    xferValid && !xferDone |=> xferValid && $stable(xferAddr) && $stable(xferLen)) else $error("offer changed early"); // R11

endmodule

bind rx_desc_walker rdw_walker_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .extMode     (extMode),
  .pollDemand  (pollDemand),
  .descUnavail (descUnavail),
  .memReq      (memReq),
  .memWe       (memWe),
  .memAddr     (memAddr),
  .memWdata    (memWdata),
  .memAck      (memAck),
  .xferValid   (xferValid),
  .xferAddr    (xferAddr),
  .xferLen     (xferLen),
  .xferDone    (xferDone)
);

// File: tb/test_rx_desc_walker.sv
module test_rx_desc_walker;

  localparam int ADDR_W = 12;
  localparam int MEM_WORDS = 1 << (ADDR_W - 2);
  localparam logic [31:0] EXTV = 32'h1234_5678;
  localparam logic [ADDR_W-1:0] BASE = 12'h100;

  typedef struct packed {
    logic        ext;
    logic        chain;
    logic        eor;
    logic [12:0] s1;
    logic [12:0] s2;
    logic [12:0] endLen;
    logic        da;
    logic [1:0]  expX;
    logic [31:0] expStat;
    logic [11:0] expNext;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 13'd64, 13'd32, 13'd32, 1'b0, 2'd2, 32'h0000_0100, 12'h110},
    '{1'b0, 1'b0, 1'b0, 13'd48, 13'd20, 13'd48, 1'b1, 2'd1, 32'h4000_0100, 12'h110},
    '{1'b0, 1'b1, 1'b0, 13'd40, 13'd24, 13'd0,  1'b0, 2'd1, 32'h0000_0000, 12'h200},
    '{1'b0, 1'b0, 1'b1, 13'd0,  13'd16, 13'd16, 1'b0, 2'd1, 32'h0000_0100, 12'h100},
    '{1'b1, 1'b0, 1'b0, 13'd64, 13'd32, 13'd32, 1'b1, 2'd2, 32'h4000_0101, 12'h120},
    '{1'b1, 1'b0, 1'b0, 13'd0,  13'd0,  13'd0,  1'b0, 2'd0, 32'h0000_0001, 12'h120},
    '{1'b0, 1'b0, 1'b0, 13'd0,  13'd0,  13'd0,  1'b0, 2'd0, 32'h0000_0000, 12'h110},
    '{1'b1, 1'b1, 1'b1, 13'd8,  13'd99, 13'd8,  1'b0, 2'd1, 32'h0000_0101, 12'h200}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              extMode = 1'b0;
  logic [ADDR_W-1:0] listBase = BASE;
  logic              pollDemand = 1'b0;
  logic              descUnavail;
  logic              memReq, memWe, memAck;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0]       memWdata, memRdata;
  logic              xferValid;
  logic [31:0]       xferAddr;
  logic [12:0]       xferLen;
  logic              xferDone = 1'b0;
  logic              xferFrameEnd = 1'b0;
  logic              xferDaFail = 1'b0;
  logic [31:0]       extStatus = EXTV;

  logic [31:0] mem [MEM_WORDS];
  logic        ackTog = 1'b0;
  int          rdCount, wrCount, xCount, moverCnt;
  logic [ADDR_W-1:0] lastRd;
  logic [31:0] logAddr [4];
  logic [12:0] logLen  [4];
  logic [12:0] endLen = '0;
  logic        daVal = 1'b0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rx_desc_walker #(.ADDR_W(ADDR_W)) i_rx_desc_walker (
    .clk(clk), .rstN(rstN), .extMode(extMode), .listBase(listBase),
    .pollDemand(pollDemand), .descUnavail(descUnavail),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .xferValid(xferValid), .xferAddr(xferAddr), .xferLen(xferLen),
    .xferDone(xferDone), .xferFrameEnd(xferFrameEnd), .xferDaFail(xferDaFail),
    .extStatus(extStatus)
  );

  // model memory: grants on alternate cycles
  assign memAck   = memReq & ackTog;
  assign memRdata = mem[memAddr[ADDR_W-1:2]];

  always @(posedge clk) begin
    ackTog <= ~ackTog;
    if (!rstN) begin
      rdCount <= 0;
      wrCount <= 0;
      lastRd  <= '0;
    end else if (memReq && memAck) begin
      if (memWe) begin
        mem[memAddr[ADDR_W-1:2]] <= memWdata;
        wrCount <= wrCount + 1;
      end else begin
        rdCount <= rdCount + 1;
        lastRd  <= memAddr;
      end
    end
  end

  // model data mover: finishes a buffer two cycles after the offer
  always @(posedge clk) begin
    if (!rstN) begin
      xferDone <= 1'b0; xferFrameEnd <= 1'b0; xferDaFail <= 1'b0;
      moverCnt <= 0; xCount <= 0;
    end else if (xferDone) begin
      xferDone <= 1'b0; xferFrameEnd <= 1'b0; xferDaFail <= 1'b0;
      moverCnt <= 0;
    end else if (xferValid) begin
      if (moverCnt == 2) begin
        xferDone     <= 1'b1;
        xferFrameEnd <= (xferLen == endLen);
        xferDaFail   <= daVal && (xferLen == endLen);
        if (xCount < 4) begin
          logAddr[xCount] <= xferAddr;
          logLen[xCount]  <= xferLen;
        end
        xCount <= xCount + 1;
      end else begin
        moverCnt <= moverCnt + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poll();
    @(negedge clk) pollDemand = 1'b1;
    @(negedge clk) pollDemand = 1'b0;
  endtask

  task automatic waitStall(input string tag);
    int n = 0;
    while (!descUnavail && n < 600) begin
      @(negedge clk);
      n++;
    end
    check(descUnavail, tag, 32'(descUnavail), 32'd1);
  endtask

  task automatic runVec(input vec_t v, input int k);
    rstN = 1'b0;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    mem[BASE >> 2]       = 32'h8000_0000;
    mem[(BASE >> 2) + 1] = {3'b000, v.s2, v.eor, v.chain, 1'b0, v.s1};
    mem[(BASE >> 2) + 2] = 32'h0000_0400;
    mem[(BASE >> 2) + 3] = v.chain ? 32'h0000_0200 : 32'h0000_0500;
    extMode = v.ext;
    endLen  = v.endLen;
    daVal   = v.da;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check(rdCount == 0, "R12 no access before poll", 32'(rdCount), 32'd0);
    poll();
    waitStall("R1 stall on host-owned next");
    check(xCount == int'(v.expX), $sformatf("R5 R6 R9 transfer count v%0d", k), 32'(xCount), 32'(v.expX));
    if (v.expX > 0) begin
      check(logAddr[0] == (v.s1 != 0 ? 32'h400 : 32'h500), $sformatf("R5 first buffer address v%0d", k),
            logAddr[0], (v.s1 != 0 ? 32'h400 : 32'h500));
      check(logLen[0] == (v.s1 != 0 ? v.s1 : v.s2), $sformatf("R5 first buffer length v%0d", k),
            32'(logLen[0]), 32'(v.s1 != 0 ? v.s1 : v.s2));
    end
    if (v.expX > 1) begin
      check(logAddr[1] == 32'h500 && logLen[1] == v.s2, $sformatf("R5 second buffer v%0d", k),
            logAddr[1], 32'h500);
    end
    check(mem[BASE >> 2] == v.expStat, $sformatf("R2 R9 status word v%0d", k), mem[BASE >> 2], v.expStat);
    check(lastRd == v.expNext, $sformatf("R7 R8 R3 R4 next descriptor v%0d", k), 32'(lastRd), 32'(v.expNext));
    check(rdCount == (v.ext ? 9 : 5), $sformatf("R3 R4 read count v%0d", k), 32'(rdCount), (v.ext ? 32'd9 : 32'd5));
    check(wrCount == (v.ext ? 2 : 1), $sformatf("R3 R4 write count v%0d", k), 32'(wrCount), (v.ext ? 32'd2 : 32'd1));
    if (v.ext) begin
      check(mem[(BASE >> 2) + 4] == (v.expX > 0 ? EXTV : 32'h0), $sformatf("R4 extended word v%0d", k),
            mem[(BASE >> 2) + 4], (v.expX > 0 ? EXTV : 32'h0));
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    check(1'b0, "watchdog", 32'(cyc), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R12 reset state
    check(!memReq && !xferValid && !descUnavail, "R12 reset outputs",
          {29'd0, memReq, xferValid, descUnavail}, 32'd0);

    for (int k = 0; k < NVEC; k++) runVec(VECS[k], k);

    // R1 stalled walker is quiet until polled, then refetches the same address
    runVec(VECS[0], 0);
    repeat (20) @(negedge clk);
    check(rdCount == 5 && descUnavail, "R1 no refetch without poll", 32'(rdCount), 32'd5);
    mem[12'h110 >> 2]       = 32'h8000_0000;
    mem[(12'h110 >> 2) + 1] = 32'h0;
    poll();
    check(!descUnavail, "R1 poll clears unavailable", 32'(descUnavail), 32'd0);
    waitStall("R1 stall after retry");
    check(mem[12'h110 >> 2] == 32'h0, "R9 empty descriptor closed", mem[12'h110 >> 2], 32'h0);
    check(lastRd == 12'h120, "R1 R3 walk continues after retry", 32'(lastRd), 32'h120);
    check(wrCount == 2 && xCount == 2, "R9 no transfer for empty descriptor", 32'(xCount), 32'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule